// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This block runs the data phase of SMBus block reads and block writes, and of I2C-style block transfers, on behalf of a host controller. Software reaches it through a small byte-wide register port. Below it, a byte-level link master carries each byte onto the wire and reports back. The engine has two modes. In buffered mode, a 32-entry byte store is filled or drained through a single block-data port whose index advances on every access. In byte mode the store is bypassed: one byte moves at a time and software acknowledges each one.

The block count lives in the count register. Software writes it before a write or an I2C-style read. For an SMBus block read, the engine fills it from the first byte received. In byte mode the engine stops after every data byte and holds the link until software clears the byte-done flag. During a read, a "last" command code written before the final byte makes the engine not-acknowledge that byte and then issue a stop.

Registers: 0 status, 1 control, 2 count, 3 block data, 4 auxiliary control.

Top module: `smbblk_engine`

## Requirements
- R1: Auxiliary control bit 1 selects buffered mode and bit 0 enables hardware PEC. Both read back from register 4, and all other bits read as zero.
- R2: Any read of the control register (1) returns the block-data index to zero. Each block-data access in buffered mode advances the index by one.
- R3: Control bit 6 starts a transfer, bit 0 selects read, and bit 3 selects I2C-style framing (codes 0x14/0x18 with bit 6 and bit 0 added). For a buffered SMBus write, the engine first sends the count byte and then the buffered bytes from index 0 in order. For an I2C-style write, it sends only the data bytes.
- R4: A buffered SMBus read takes its first received byte as the count and stores it in register 2. The data bytes then fill the store from index 0. The final byte alone is not-acknowledged. An I2C-style read takes its length from register 2.
- R5: A count outside 1 to 32 is a protocol error and sets status bit 4. This applies to a received count, which ends the transfer with a stop, and to a written count checked at start, which starts nothing. No further data byte moves and completion is not flagged.
- R6: In buffered mode, pushes beyond 32 bytes are dropped and the index stays at 32. Reads at index 32 return zero.
- R7: In byte mode, status bit 7 sets after each data byte. The link stays idle until software writes 1 to that bit.
- R8: In a byte-mode write, the next byte sent is the value written to the block-data port before byte-done is cleared.
- R9: In a byte-mode read, the byte requested while control bit 5 is set (codes 0x34/0x38) is not-acknowledged and is followed by a stop. Control writes during a transfer change the command bits but never start a second transfer.
- R10: Status bit 0 shows busy. Status bit 1 sets only when the closing stop finishes, never per byte. Status bits 7, 4 and 1 clear when 1 is written to them.
- R11: After reset all registers read zero and no link request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (for side effects) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| lnk_req_o | output | 1 | Byte request to the link master, held until done |
| lnk_rd_o | output | 1 | Request is a receive |
| lnk_nack_o | output | 1 | Do not acknowledge the byte being received |
| lnk_stop_o | output | 1 | Request is a stop condition |
| lnk_wdata_o | output | 8 | Byte to send |
| lnk_done_i | input | 1 | Link master finished the request |
| lnk_rdata_i | input | 8 | Received byte, valid with done |

## Verification
The bench builds the engine with its default 32-entry store and 8-bit data. Transfers of the full 32 bytes, a 33rd dropped push and a read at the saturated index are therefore all within reach. The vector table covers both directions and both framings at lengths 1 to 32. Directed cases cover counts of 0, 33 and 40, the byte-mode stall with an idle link, and a late "last" code.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_STAT = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] A_BLK  = 3'd3;
  localparam logic [REG_AW-1:0] A_AUX  = 3'd4;

  // control field positions
  localparam int C_RD    = 0;
  localparam int C_I2C   = 3;
  localparam int C_LAST  = 5;
  localparam int C_START = 6;

  // status field positions
  localparam int S_BUSY = 0;
  localparam int S_CMPL = 1;
  localparam int S_PERR = 4;
  localparam int S_BD   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_DATA,
    ST_HOLD,
    ST_STOP
  } seq_state_e;
endpackage

// File: rtl/smbblk_buf.sv
module smbblk_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          sw_we_i,
  input  logic [IW-1:0] sw_idx_i,
  input  logic [DW-1:0] sw_wd_i,
  output logic [DW-1:0] sw_rd_o,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_idx_i,
  input  logic [DW-1:0] eng_wd_i,
  output logic [DW-1:0] eng_rd_o
);
  logic [DW-1:0] mem [DEPTH];

  logic sw_ok, eng_ok;
  assign sw_ok  = sw_idx_i < IW'(DEPTH);
  assign eng_ok = eng_idx_i < IW'(DEPTH);

  // engine port wins on a same-entry collision
  always_ff @(posedge clk_i) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (eng_we_i && eng_ok && eng_idx_i[AW-1:0] == AW'(e))
        mem[e] <= eng_wd_i;
      else if (sw_we_i && sw_ok && sw_idx_i[AW-1:0] == AW'(e))
        mem[e] <= sw_wd_i;
    end
  end

  assign sw_rd_o  = sw_ok  ? mem[sw_idx_i[AW-1:0]]  : '0;
  assign eng_rd_o = eng_ok ? mem[eng_idx_i[AW-1:0]] : '0;
endmodule

// File: rtl/smbblk_seq.sv
module smbblk_seq
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic          i2c_i,
  input  logic          buf_en_i,
  input  logic          last_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          byte_done_i,
  input  logic [DW-1:0] hold_i,
  input  logic [DW-1:0] buf_rd_i,
  output logic [IW-1:0] eng_idx_o,
  output logic          buf_we_o,
  output logic          hold_we_o,
  output logic          cnt_we_o,
  output logic          bd_set_o,
  output logic          done_set_o,
  output logic          perr_set_o,
  output logic          busy_o,
  output logic          lnk_req_o,
  output logic          lnk_rd_o,
  output logic          lnk_nack_o,
  output logic          lnk_stop_o,
  output logic [DW-1:0] lnk_wdata_o,
  input  logic          lnk_done_i,
  input  logic [DW-1:0] lnk_rdata_i
);
  seq_state_e    st_q, st_d;
  logic [IW-1:0] k_q, k_d;
  logic [DW-1:0] len_q, len_d;
  logic          rd_q, rd_d, i2c_q, i2c_d, bm_q, bm_d;
  logic          fin_q, fin_d, err_q, err_d;
  logic [DW-1:0] kp1;
  logic          nack, fin;

  function automatic logic in_range(input logic [DW-1:0] n);
    return (n != '0) && (n <= DW'(DEPTH));
  endfunction

  assign kp1  = DW'(k_q) + DW'(1);
  assign nack = rd_q && (bm_q ? (kp1 == len_q) : last_i);
  assign fin  = rd_q ? nack : (kp1 == len_q);

  always_comb begin
    st_d = st_q; k_d = k_q; len_d = len_q; fin_d = fin_q; err_d = err_q;
    rd_d = rd_q; i2c_d = i2c_q; bm_d = bm_q;
    buf_we_o = 1'b0; hold_we_o = 1'b0; cnt_we_o = 1'b0;
    bd_set_o = 1'b0; done_set_o = 1'b0; perr_set_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        rd_d = rd_i; i2c_d = i2c_i; bm_d = buf_en_i;
        k_d = '0; len_d = cnt_i; err_d = 1'b0;
        // length known up front: reject before touching the bus
        if ((!rd_i || (i2c_i && buf_en_i)) && !in_range(cnt_i))
          perr_set_o = 1'b1;
        else
          st_d = i2c_i ? ST_DATA : ST_CNT;
      end
      ST_CNT: if (lnk_done_i) begin
        if (rd_q) begin
          cnt_we_o = 1'b1;
          if (!in_range(lnk_rdata_i)) begin
            perr_set_o = 1'b1; err_d = 1'b1; st_d = ST_STOP;
          end else begin
            len_d = lnk_rdata_i; st_d = ST_DATA;
          end
        end else begin
          st_d = ST_DATA;
        end
      end
      ST_DATA: if (lnk_done_i) begin
        k_d = k_q + IW'(1);
        if (rd_q) begin
          buf_we_o  = bm_q;
          hold_we_o = !bm_q;
        end
        if (bm_q) begin
          st_d = fin ? ST_STOP : ST_DATA;
        end else begin
          bd_set_o = 1'b1; fin_d = fin; st_d = ST_HOLD;
        end
      end
      ST_HOLD: if (!byte_done_i) st_d = fin_q ? ST_STOP : ST_DATA;
      ST_STOP: if (lnk_done_i) begin
        done_set_o = !err_q;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; k_q <= '0; len_q <= '0; fin_q <= 1'b0; err_q <= 1'b0;
      rd_q <= 1'b0; i2c_q <= 1'b0; bm_q <= 1'b0;
    end else begin
      st_q <= st_d; k_q <= k_d; len_q <= len_d; fin_q <= fin_d; err_q <= err_d;
      rd_q <= rd_d; i2c_q <= i2c_d; bm_q <= bm_d;
    end
  end

  assign eng_idx_o   = k_q;
  assign busy_o      = st_q != ST_IDLE;
  assign lnk_req_o   = (st_q == ST_CNT) || (st_q == ST_DATA) || (st_q == ST_STOP);
  assign lnk_stop_o  = st_q == ST_STOP;
  assign lnk_rd_o    = rd_q && (st_q != ST_STOP) && lnk_req_o;
  assign lnk_nack_o  = (st_q == ST_DATA) && nack;
  assign lnk_wdata_o = (st_q == ST_CNT)  ? len_q :
                       (st_q == ST_DATA) ? (bm_q ? buf_rd_i : hold_i) : '0;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_req_o && !lnk_done_i) |=> (lnk_req_o && $stable(lnk_stop_o)));
  // R7
  bd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && busy_o && !bm_q) |-> !lnk_req_o);
  // R9
  nack_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_nack_o |-> (lnk_rd_o && !lnk_stop_o));
  // R10
  cmpl_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_o |-> (lnk_stop_o && lnk_done_i));
  // R5
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(perr_set_o && done_set_o));
endmodule

// File: rtl/smbblk_engine.sv
module smbblk_engine
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              lnk_req_o,
  output logic              lnk_rd_o,
  output logic              lnk_nack_o,
  output logic              lnk_stop_o,
  output logic [DW-1:0]     lnk_wdata_o,
  input  logic              lnk_done_i,
  input  logic [DW-1:0]     lnk_rdata_i
);
  logic [DW-1:0] ctrl_q, cnt_q, hold_q;
  logic [1:0]    aux_q;
  logic [IW-1:0] idx_q, eng_idx;
  logic          bd_q, perr_q, cmpl_q;
  logic          busy, start;
  logic          buf_we, hold_we, cnt_we, bd_set, done_set, perr_set;
  logic [DW-1:0] sw_rd, eng_rd;
  logic          wr_stat, wr_ctrl, wr_cnt, wr_blk, wr_aux, rd_ctrl, rd_blk;
  logic          sw_buf_we;

  assign wr_stat = reg_wr_i && reg_addr_i == A_STAT;
  assign wr_ctrl = reg_wr_i && reg_addr_i == A_CTRL;
  assign wr_cnt  = reg_wr_i && reg_addr_i == A_CNT;
  assign wr_blk  = reg_wr_i && reg_addr_i == A_BLK;
  assign wr_aux  = reg_wr_i && reg_addr_i == A_AUX;
  assign rd_ctrl = reg_rd_i && reg_addr_i == A_CTRL;
  assign rd_blk  = reg_rd_i && reg_addr_i == A_BLK;

  assign start     = wr_ctrl && reg_wdata_i[C_START] && !busy;
  assign sw_buf_we = wr_blk && aux_q[1];

  smbblk_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i     (clk_i),
    .sw_we_i   (sw_buf_we),
    .sw_idx_i  (idx_q),
    .sw_wd_i   (reg_wdata_i),
    .sw_rd_o   (sw_rd),
    .eng_we_i  (buf_we),
    .eng_idx_i (eng_idx),
    .eng_wd_i  (lnk_rdata_i),
    .eng_rd_o  (eng_rd)
  );

  smbblk_seq #(.DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .rd_i        (reg_wdata_i[C_RD]),
    .i2c_i       (reg_wdata_i[C_I2C]),
    .buf_en_i    (aux_q[1]),
    .last_i      (ctrl_q[C_LAST]),
    .cnt_i       (cnt_q),
    .byte_done_i (bd_q),
    .hold_i      (hold_q),
    .buf_rd_i    (eng_rd),
    .eng_idx_o   (eng_idx),
    .buf_we_o    (buf_we),
    .hold_we_o   (hold_we),
    .cnt_we_o    (cnt_we),
    .bd_set_o    (bd_set),
    .done_set_o  (done_set),
    .perr_set_o  (perr_set),
    .busy_o      (busy),
    .lnk_req_o   (lnk_req_o),
    .lnk_rd_o    (lnk_rd_o),
    .lnk_nack_o  (lnk_nack_o),
    .lnk_stop_o  (lnk_stop_o),
    .lnk_wdata_o (lnk_wdata_o),
    .lnk_done_i  (lnk_done_i),
    .lnk_rdata_i (lnk_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; cnt_q <= '0; hold_q <= '0; aux_q <= '0; idx_q <= '0;
      bd_q <= 1'b0; perr_q <= 1'b0; cmpl_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i & ~(DW'(1) << C_START);
      if (wr_aux)  aux_q  <= reg_wdata_i[1:0];

      if (cnt_we)      cnt_q <= lnk_rdata_i;
      else if (wr_cnt) cnt_q <= reg_wdata_i;

      if (hold_we)                 hold_q <= lnk_rdata_i;
      else if (wr_blk && !aux_q[1]) hold_q <= reg_wdata_i;

      // control read rewinds; buffered port accesses advance and saturate
      if (rd_ctrl)
        idx_q <= '0;
      else if ((wr_blk || rd_blk) && aux_q[1] && idx_q < IW'(DEPTH))
        idx_q <= idx_q + IW'(1);

      if (bd_set)                          bd_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[S_BD]) bd_q <= 1'b0;
      if (perr_set)                            perr_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[S_PERR]) perr_q <= 1'b0;
      if (done_set)                            cmpl_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[S_CMPL]) cmpl_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STAT: begin
        reg_rdata_o[S_BD]   = bd_q;
        reg_rdata_o[S_PERR] = perr_q;
        reg_rdata_o[S_CMPL] = cmpl_q;
        reg_rdata_o[S_BUSY] = busy;
      end
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_CNT:   reg_rdata_o = cnt_q;
      A_BLK:   reg_rdata_o = aux_q[1] ? sw_rd : hold_q;
      A_AUX:   reg_rdata_o[1:0] = aux_q;
      default: reg_rdata_o = '0;
    endcase
  end

  // R6
  idx_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(DEPTH));
  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (cmpl_q || perr_q));
endmodule

// File: tb/smbblk_engine_test.sv
module smbblk_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       req, lrd, nack, stop, done = 1'b0;
  logic [7:0] lwd, lrdata = '0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smbblk_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lnk_req_o(req), .lnk_rd_o(lrd),
    .lnk_nack_o(nack), .lnk_stop_o(stop), .lnk_wdata_o(lwd), .lnk_done_i(done),
    .lnk_rdata_i(lrdata)
  );

  // link master stub
  logic [7:0] rx_src [64];
  logic [7:0] tx_log [64];
  int tx_n = 0, rx_p = 0, nack_n = 0, nack_at = -1, stop_n = 0, dly = 0;
  logic stub_clr = 1'b0;

  always @(posedge clk) begin
    if (stub_clr) begin
      tx_n <= 0; rx_p <= 0; nack_n <= 0; nack_at <= -1; stop_n <= 0;
      dly <= 0; done <= 1'b0;
    end else if (done) begin
      done <= 1'b0;
    end else if (req) begin
      if (dly == 2) begin
        dly <= 0; done <= 1'b1;
        if (stop) stop_n <= stop_n + 1;
        else if (lrd) begin
          lrdata <= rx_src[rx_p]; rx_p <= rx_p + 1;
          if (nack) begin nack_n <= nack_n + 1; nack_at <= rx_p; end
        end else begin
          tx_log[tx_n] <= lwd; tx_n <= tx_n + 1;
        end
      end else dly <= dly + 1;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic clr_stub();
    @(negedge clk); stub_clr = 1'b1;
    @(negedge clk); stub_clr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wait_bd();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd0, s);
      if (s[7]) break;
    end
  endtask

  // {read, i2c, count}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd3}, {1'b0, 1'b1, 8'd1}, {1'b1, 1'b0, 8'd5},
    {1'b1, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd32}, {1'b1, 1'b0, 8'd32}
  };

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'(v * 16 + i * 3 + 1);
  endfunction

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    reg_rd(3'd0, d); chk("R11 status", d, 0);
    reg_rd(3'd1, d); chk("R11 control", d, 0);
    reg_rd(3'd2, d); chk("R11 count", d, 0);
    reg_rd(3'd4, d); chk("R11 aux", d, 0);
    chk("R11 link idle", req, 0);

    // R1 aux readback
    reg_wr(3'd4, 8'h03); reg_rd(3'd4, d); chk("R1 aux both", d, 8'h03);
    reg_wr(3'd4, 8'hFE); reg_rd(3'd4, d); chk("R1 aux mask", d, 8'h02);

    // vector walk: buffered transfers (R3, R4, R10)
    for (int v = 0; v < 6; v++) begin
      logic vrd, vi2c; int cnt, off;
      vrd = VEC[v][9]; vi2c = VEC[v][8]; cnt = int'(VEC[v][7:0]);
      off = vi2c ? 0 : 1;
      clr_stub();
      reg_wr(3'd4, 8'h02);
      reg_rd(3'd1, d);
      if (!vrd) begin
        reg_wr(3'd2, 8'(cnt));
        for (int i = 0; i < cnt; i++) reg_wr(3'd3, pat(v, i));
        reg_wr(3'd1, vi2c ? 8'h58 : 8'h54);
        wait_idle();
        chk("R3 bytes sent", tx_n, cnt + off);
        if (!vi2c) chk("R3 count byte first", tx_log[0], cnt);
        bad = 0;
        for (int i = 0; i < cnt; i++) if (tx_log[i + off] !== pat(v, i)) bad++;
        chk("R3 data order", bad, 0);
      end else begin
        if (!vi2c) rx_src[0] = 8'(cnt);
        for (int i = 0; i < cnt; i++) rx_src[i + off] = pat(v, i);
        if (vi2c) reg_wr(3'd2, 8'(cnt));
        reg_wr(3'd1, vi2c ? 8'h59 : 8'h55);
        wait_idle();
        reg_rd(3'd2, d); chk("R4 count reg", d, cnt);
        reg_rd(3'd1, d);
        bad = 0;
        for (int i = 0; i < cnt; i++) begin
          reg_rd(3'd3, d);
          if (d !== pat(v, i)) bad++;
        end
        chk("R4 data from index 0", bad, 0);
        chk("R4 one nack", nack_n, 1);
        chk("R4 nack on final", nack_at, cnt - 1 + off);
      end
      reg_rd(3'd0, d); chk("R10 complete after stop", d, 8'h02);
      chk("R10 one stop", stop_n, 1);
      reg_wr(3'd0, 8'h02); reg_rd(3'd0, d); chk("R10 complete w1c", d, 0);
    end

    // R2 index rewind on control read
    reg_wr(3'd4, 8'h02); reg_rd(3'd1, d);
    reg_wr(3'd3, 8'h11); reg_wr(3'd3, 8'h22); reg_wr(3'd3, 8'h33);
    reg_rd(3'd1, d);
    reg_rd(3'd3, d); chk("R2 first after rewind", d, 8'h11);
    reg_rd(3'd3, d); chk("R2 advance", d, 8'h22);
    reg_rd(3'd1, d);
    reg_rd(3'd3, d); chk("R2 rewind again", d, 8'h11);

    // R6 overflow drop and saturation
    reg_rd(3'd1, d);
    for (int i = 0; i < 32; i++) reg_wr(3'd3, 8'(8'h40 + i));
    reg_wr(3'd3, 8'hEE);
    reg_rd(3'd1, d);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      reg_rd(3'd3, d);
      if (d !== 8'(8'h40 + i)) bad++;
    end
    chk("R6 33rd push dropped", bad, 0);
    reg_rd(3'd3, d); chk("R6 saturated read zero", d, 0);

    // R5 received count out of range
    clr_stub();
    rx_src[0] = 8'd0;
    reg_wr(3'd1, 8'h55); wait_idle();
    reg_rd(3'd0, d); chk("R5 count 0 flags error only", d, 8'h10);
    chk("R5 no data fetched", rx_p, 1);
    chk("R5 stop issued", stop_n, 1);
    reg_wr(3'd0, 8'h10);
    clr_stub();
    rx_src[0] = 8'd40;
    reg_wr(3'd1, 8'h55); wait_idle();
    reg_rd(3'd0, d); chk("R5 count 40", d, 8'h10);
    reg_wr(3'd0, 8'h10);
    clr_stub();
    reg_wr(3'd2, 8'd33); reg_wr(3'd1, 8'h54);
    reg_rd(3'd0, d); chk("R5 write count 33 at start", d, 8'h10);
    repeat (10) @(negedge clk);
    chk("R5 nothing sent", tx_n, 0);
    reg_wr(3'd0, 8'h10);

    // byte-mode write (R7, R8, R10)
    clr_stub();
    reg_wr(3'd4, 8'h00);
    reg_wr(3'd2, 8'd3); reg_wr(3'd3, 8'hA1);
    reg_wr(3'd1, 8'h54);
    wait_bd();
    chk("R7 count and first byte", tx_n, 2);
    reg_rd(3'd0, d); chk("R10 no complete mid-block", d, 8'h81);
    repeat (20) @(negedge clk);
    chk("R7 link stalled", tx_n, 2);
    reg_wr(3'd3, 8'hA2); reg_wr(3'd0, 8'h80);
    wait_bd();
    reg_wr(3'd3, 8'hA3); reg_wr(3'd0, 8'h80);
    wait_bd();
    reg_wr(3'd0, 8'h80);
    wait_idle();
    chk("R8 byte 0", tx_log[0], 8'h03);
    chk("R8 byte 1", tx_log[1], 8'hA1);
    chk("R8 byte 2", tx_log[2], 8'hA2);
    chk("R8 byte 3", tx_log[3], 8'hA3);
    reg_rd(3'd0, d); chk("R10 byte-mode complete", d, 8'h02);
    reg_wr(3'd0, 8'h02);

    // byte-mode read with late last code (R9, R7)
    clr_stub();
    rx_src[0] = 8'd3; rx_src[1] = 8'hB1; rx_src[2] = 8'hB2; rx_src[3] = 8'hB3;
    reg_wr(3'd1, 8'h55);
    wait_bd();
    reg_rd(3'd2, d); chk("R9 count received", d, 3);
    reg_rd(3'd3, d); chk("R9 byte 1", d, 8'hB1);
    reg_wr(3'd1, 8'h55);
    reg_wr(3'd0, 8'h80);
    wait_bd();
    reg_rd(3'd3, d); chk("R9 byte 2", d, 8'hB2);
    chk("R9 no early nack", nack_n, 0);
    reg_wr(3'd1, 8'h35);
    reg_wr(3'd0, 8'h80);
    wait_bd();
    reg_rd(3'd3, d); chk("R9 byte 3", d, 8'hB3);
    chk("R9 nack on last", nack_at, 3);
    reg_wr(3'd0, 8'h80);
    wait_idle();
    chk("R9 no restart", rx_p, 4);
    chk("R9 single stop", stop_n, 1);
    reg_rd(3'd0, d); chk("R10 read complete", d, 8'h02);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule